// File: doc/BRIEF.md
# Clock-Sampled Transparent Latch Emulator

This block stands in for a level-sensitive transparent latch, with optional per-bit forcing to one and forcing to zero, in a design where every storage element must be a flip-flop on a single global clock. Its output is combinational. While the enable input sits at its active level, the output follows the data input in the same cycle. Otherwise the output shows a held copy, which is the output value taken at the most recent rising clock edge.

The held copy is a plain flip-flop bank that reloads from the output on every rising edge. A multiplexer in front of it selects between the data input and the held value. The force-high and force-low masks are then merged into the selected value. Each of the three controls has a polarity parameter. Every bit can carry a defined start value, which the flop bank takes during reset. Bits with no defined start value have no reset and remain unknown until they are first written.

Top module: `level_latch_emu`

## Requirements
- R1: While the enable is active, each output bit that is neither forced high nor forced low equals the matching `d_i` bit in the same cycle, with no clock edge in between.
- R2: While the enable is inactive, each output bit that is neither forced high nor forced low equals the value that bit had on `q_o` just before the most recent rising clock edge.
- R3: `EN_HIGH`=1 makes `en_i`=1 the active level. `EN_HIGH`=0 makes `en_i`=0 the active level.
- R4: With `HAS_SETCLR`=1, an active `set_i` bit forces the matching output bit to 1 in the same cycle. `SET_HIGH` selects the active level of `set_i` (1 means active high, 0 means active low).
- R5: With `HAS_SETCLR`=1, an active `clr_i` bit forces the matching output bit to 0 in the same cycle. A clear wins over a set on the same bit. `CLR_HIGH` selects the active level of `clr_i` (1 means active high, 0 means active low).
- R6: Forcing works bit by bit. A bit whose `set_i` and `clr_i` are both inactive follows R1 or R2, whatever is forced on the other bits.
- R7: While `rst_n` is low, every bit with a 1 in `INIT_MASK` holds the matching `INIT_VALUE` bit as its held value. With the enable inactive and nothing forced, `q_o` shows that value.
- R8: With `HAS_SETCLR`=0, `set_i` and `clr_i` have no effect on `q_o`.
- R9: The held copy reloads on every rising edge outside reset, whatever the enable level. A value that is forced or passed through before an edge is still shown after the force or the enable is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the defined start values |
| en_i | input | 1 | Transparency enable, active level set by `EN_HIGH` |
| d_i | input | WIDTH | Data input |
| set_i | input | WIDTH | Per-bit force-to-one mask, active level set by `SET_HIGH` |
| clr_i | input | WIDTH | Per-bit force-to-zero mask, active level set by `CLR_HIGH` |
| q_o | output | WIDTH | Emulated latch output |

## Verification
The only internal state is the held copy. If a wrong value gets into it, the error stays hidden while the enable is active or while a bit is forced. It shows on `q_o` in the first cycle with the enable inactive and nothing forced, and it then stays there until the bit is passed through or forced again. The scoreboard therefore follows every pass-through or force step with hold cycles, so that a missed reload, a wrong start value or a wrong polarity appears within one cycle. Three instances cover both polarity settings and the variant without forcing. Bits with no defined start value are compared only after they have first been written.

// File: rtl/lemu_pkg.sv
`timescale 1ns/1ps
package lemu_pkg;

  // Source of the unforced output value.
  typedef enum logic {
    SRC_HOLD = 1'b0,
    SRC_DATA = 1'b1
  } src_sel_e;

  // Maps a control level onto its active-high meaning.
  function automatic logic lvl_to_active(input logic lvl, input logic act_high);
    return act_high ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/lemu_pol_norm.sv
`timescale 1ns/1ps
module lemu_pol_norm #(
  parameter int   WIDTH    = 8,
  parameter logic ACT_HIGH = 1'b1
) (
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] act_o
);

  // One normaliser per bit, so the polarity choice is made at elaboration.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign act_o[b] = lemu_pkg::lvl_to_active(raw_i[b], ACT_HIGH);
  end

endmodule

// File: rtl/lemu_hold_reg.sv
`timescale 1ns/1ps
module lemu_hold_reg #(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] INIT_MASK  = '1,
  parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_q_i,
  output logic [WIDTH-1:0] held_q_o
);

  logic [WIDTH-1:0] held_nxt;

  // Next-state process: the held copy takes the present output on each edge.
  always_comb begin
    held_nxt = cur_q_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (INIT_MASK[b]) begin : g_rst
      // Bit with a defined start value: asynchronous reset to that value.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q_o[b] <= INIT_VALUE[b];
        else        held_q_o[b] <= held_nxt[b];
      end
    end else begin : g_norst
      // Bit without a start value: no reset, unknown until first written.
      always_ff @(posedge clk) begin
        held_q_o[b] <= held_nxt[b];
      end
    end
  end

endmodule

// File: rtl/lemu_merge.sv
`timescale 1ns/1ps
module lemu_merge #(
  parameter int   WIDTH      = 8,
  parameter logic HAS_SETCLR = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lemu_pkg::src_sel_e  sel_i,
  input  logic [WIDTH-1:0]    d_i,
  input  logic [WIDTH-1:0]    held_i,
  input  logic [WIDTH-1:0]    set_act_i,
  input  logic [WIDTH-1:0]    clr_act_i,
  output logic [WIDTH-1:0]    q_o
);
  import lemu_pkg::*;

  localparam logic [WIDTH-1:0] OVR_EN = HAS_SETCLR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] pick;
  logic [WIDTH-1:0] set_eff;
  logic [WIDTH-1:0] clr_eff;

  always_comb begin
    pick    = (sel_i == SRC_DATA) ? d_i : held_i;
    set_eff = set_act_i & OVR_EN;
    clr_eff = clr_act_i & OVR_EN;
    // The clear is applied last, so it wins over the set.
    q_o     = (pick | set_eff) & ~clr_eff;
  end

  if (HAS_SETCLR) begin : g_ovr_chk
    assert_set_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_o & set_act_i & ~clr_act_i) == (set_act_i & ~clr_act_i)))
      else $error("R4 set bit not driven high");
    assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_o & clr_act_i) == '0))
      else $error("R5 cleared bit not low");
  end else begin : g_noovr_chk
    assert_ovr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SRC_HOLD) |-> (q_o === held_i))
      else $error("R8 force inputs reached output");
  end

endmodule

// File: rtl/level_latch_emu.sv
`timescale 1ns/1ps
module level_latch_emu #(
  parameter int               WIDTH      = 8,
  parameter logic             EN_HIGH    = 1'b1,
  parameter logic             SET_HIGH   = 1'b1,
  parameter logic             CLR_HIGH   = 1'b1,
  parameter logic             HAS_SETCLR = 1'b1,
  parameter logic [WIDTH-1:0] INIT_MASK  = '1,
  parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  import lemu_pkg::*;

  logic [0:0]       en_raw;
  logic [0:0]       en_act;
  logic [WIDTH-1:0] set_act;
  logic [WIDTH-1:0] clr_act;
  logic [WIDTH-1:0] held_q;
  src_sel_e         sel;

  assign en_raw = en_i;

  lemu_pol_norm #(.WIDTH(1), .ACT_HIGH(EN_HIGH)) u_en_norm (
    .raw_i (en_raw),
    .act_o (en_act)
  );

  lemu_pol_norm #(.WIDTH(WIDTH), .ACT_HIGH(SET_HIGH)) u_set_norm (
    .raw_i (set_i),
    .act_o (set_act)
  );

  lemu_pol_norm #(.WIDTH(WIDTH), .ACT_HIGH(CLR_HIGH)) u_clr_norm (
    .raw_i (clr_i),
    .act_o (clr_act)
  );

  always_comb begin
    sel = en_act[0] ? SRC_DATA : SRC_HOLD;
  end

  lemu_merge #(.WIDTH(WIDTH), .HAS_SETCLR(HAS_SETCLR)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .d_i       (d_i),
    .held_i    (held_q),
    .set_act_i (set_act),
    .clr_act_i (clr_act),
    .q_o       (q_o)
  );

  lemu_hold_reg #(.WIDTH(WIDTH), .INIT_MASK(INIT_MASK), .INIT_VALUE(INIT_VALUE)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_q_i  (q_o),
    .held_q_o (held_q)
  );

  // Bits not forced in this cycle.
  logic [WIDTH-1:0] free_m;
  assign free_m = HAS_SETCLR ? ~(set_act | clr_act) : {WIDTH{1'b1}};

  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == EN_HIGH) |-> ((q_o & free_m) === (d_i & free_m)))
    else $error("R1 output not following data");

  assert_opaque_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i != EN_HIGH) |-> ((q_o & free_m) === (held_q & free_m)))
    else $error("R2 output not holding");

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (held_q === $past(q_o)))
    else $error("R9 held copy missed reload");

  assert_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (((held_q ^ INIT_VALUE) & INIT_MASK) == '0))
    else $error("R7 start value lost");

endmodule

// File: tb/level_latch_emu_tb.sv
`timescale 1ns/1ps
module level_latch_emu_tb_top;

  localparam int         W     = 8;
  localparam logic [7:0] IMASK = 8'h0F;
  localparam logic [7:0] IVAL  = 8'h05;

  typedef struct {
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    logic [7:0] exp_c;
    logic [7:0] kn_a;
    logic [7:0] kn_c;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic [7:0] d = '0, s = '0, c = '0;
  logic [7:0] q_a, q_b, q_c;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  sb_item_t   sbq[$];
  logic [7:0] past_a, past_c, kn_a, kn_c;

  always #2 clk = ~clk;   // 250 MHz

  // Active-high controls on all inputs.
  level_latch_emu #(.WIDTH(W), .INIT_MASK(IMASK), .INIT_VALUE(IVAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(d), .set_i(s), .clr_i(c), .q_o(q_a));

  // Active-low controls, fed the inverted logical stimulus.
  level_latch_emu #(.WIDTH(W), .EN_HIGH(1'b0), .SET_HIGH(1'b0), .CLR_HIGH(1'b0),
                    .INIT_MASK(IMASK), .INIT_VALUE(IVAL)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .en_i(~en), .d_i(d), .set_i(~s), .clr_i(~c), .q_o(q_b));

  // No forcing: set and clear must be ignored.
  level_latch_emu #(.WIDTH(W), .HAS_SETCLR(1'b0), .INIT_MASK(IMASK), .INIT_VALUE(IVAL)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .d_i(d), .set_i(s), .clr_i(c), .q_o(q_c));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] kn);
    total++;
    if (((act ^ exp) & kn) != 0) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h (mask %02h)", tag, act & kn, exp & kn, kn);
    end
  endtask

  // Driver: applies one logical step and pushes the expected outputs.
  task automatic step(input logic e, input logic [7:0] dv, input logic [7:0] sv,
                      input logic [7:0] cv, input string tag);
    sb_item_t it;
    @(negedge clk);
    en = e; d = dv; s = sv; c = cv;
    it.exp_a = ((e ? dv : past_a) | sv) & ~cv;
    it.exp_b = it.exp_a;
    it.exp_c = e ? dv : past_c;
    kn_a = kn_a | (e ? 8'hFF : (sv | cv));
    kn_c = kn_c | (e ? 8'hFF : 8'h00);
    it.kn_a = kn_a;
    it.kn_c = kn_c;
    it.tag  = tag;
    sbq.push_back(it);
    past_a = it.exp_a;   // captured by the next rising edge (R9)
    past_c = it.exp_c;
  endtask

  // Monitor: compares just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        check({it.tag, " hi-pol"}, q_a, it.exp_a, it.kn_a);
        check({it.tag, " lo-pol R3"}, q_b, it.exp_b, it.kn_a);
        check({it.tag, " no-force R8"}, q_c, it.exp_c, it.kn_c);
      end
    end
  end

  initial begin
    #100000;
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    d = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R7: start values visible with enable inactive during reset.
    check("R7 reset hi-pol", q_a, IVAL, IMASK);
    check("R7 reset lo-pol", q_b, IVAL, IMASK);
    check("R7 reset no-force", q_c, IVAL, IMASK);
    rst_n = 1'b1;
    past_a = IVAL; past_c = IVAL; kn_a = IMASK; kn_c = IMASK;

    step(1'b0, 8'hAA, 8'h00, 8'h00, "R2 R7 hold start value");
    step(1'b1, 8'h3C, 8'h00, 8'h00, "R1 R3 transparent");
    step(1'b1, 8'hC3, 8'h00, 8'h00, "R1 follow new data");
    step(1'b0, 8'h00, 8'h00, 8'h00, "R9 R2 hold after enable drop");
    step(1'b0, 8'hFF, 8'h00, 8'h00, "R2 data ignored while opaque");
    step(1'b0, 8'hFF, 8'h11, 8'h00, "R4 set while opaque");
    step(1'b0, 8'hFF, 8'h00, 8'h00, "R9 set value retained");
    step(1'b0, 8'h00, 8'h00, 8'h81, "R5 clear while opaque");
    step(1'b0, 8'h00, 8'hF0, 8'h30, "R5 clear wins over set");
    step(1'b0, 8'h00, 8'h00, 8'h00, "R9 R6 merged value retained");
    step(1'b1, 8'h0F, 8'h80, 8'h01, "R6 per-bit force while transparent");
    step(1'b1, 8'h5A, 8'h00, 8'h00, "R1 transparent again");
    step(1'b0, 8'h00, 8'hFF, 8'hFF, "R5 full clear and set");
    step(1'b0, 8'h00, 8'h00, 8'h00, "R2 all-zero held");
    for (int i = 0; i < 60; i++) begin
      logic       e;
      logic [7:0] dv, sv, cv;
      e  = 1'($urandom_range(0, 1));
      dv = 8'($urandom);
      sv = 8'($urandom) & 8'($urandom);
      cv = 8'($urandom) & 8'($urandom);
      step(e, dv, sv, cv, "R6 mixed pattern");
      step(1'b0, 8'($urandom), 8'h00, 8'h00, "R2 R9 hold after mixed");
    end
    repeat (2) @(negedge clk);
    #2;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule